// File: doc/BRIEF.md
# System-Management Interrupt Entry and Resume Sequencer

This block moves a simple CPU core model into system-management mode and back again. A management interrupt request is held as pending until the core reports an instruction boundary. Once accepted, the sequencer takes a snapshot of the core's architectural registers. It waits until the core's store queue has drained, then writes a ten-word state image into the top of the save area. The save area is the 64 KB window that starts at the current relocatable base. Finally it pushes the handler's starting register values to the core through a register-load port.

When the handler asks to resume, the sequencer reads the ten words back. It takes the new base from the base slot and refuses to resume if that base is not a multiple of 32 KB; in that case it parks in a sticky shutdown state. Otherwise it chooses where execution continues: the instruction after the interrupted one, the previous instruction (to re-run a trapped I/O access), or a return to the halted state. It then reloads the core. The core datapath sees only a register vector with a one-cycle load strobe. The save memory sees a plain port with single-cycle writes and reads whose data arrives one cycle later.

Top module: `smm_seq`

## Requirements
- R1: A request pulse on `smi_req` is latched and taken only in a cycle where `insn_boundary` is high and the sequencer is idle. A request that arrives while in management mode stays pending and is taken straight after resume.
- R2: After acceptance no save write occurs while `store_pending` is high. `busy` is high from the cycle after acceptance until the cycle of the last save write, and low afterwards.
- R3: The save image is ten 32-bit words, written one per cycle with `mem_we`. Word k goes to base + FFFCh − 4k. The word order is: 0 CR0, 1 EFLAGS, 2 EIP, 3 previous EIP, 4 CS selector (zero-extended), 5 CS base, 6 revision identifier, 7 base slot, 8 restart word, 9 I/O trap word.
- R4: On entry `ld_valid` pulses for one cycle with EIP 00008000h, EFLAGS 00000002h, CS base equal to the current base and CS selector equal to base bits 19:4. CR0 is loaded with bits 0, 2, 3 and 31 cleared and all other bits kept. `in_smm` (which masks maskable interrupts and NMI) rises with that pulse.
- R5: After reset the base is 00030000h, and `busy`, `in_smm`, `ld_valid`, `shutdown` and `mem_we` are low.
- R6: The I/O trap word is {I/O address[15:0], 14 zero bits, valid, direction}. The valid bit is set only when the accepted request interrupted an I/O instruction, so it is 0 for the second request of a back-to-back pair.
- R7: The revision word is written as 00030000h. The restart word holds the I/O restart byte at bits 23:16, written as 00h, and the halt slot at bits 15:0, written as 1 if the core was halted at acceptance and as 0 otherwise.
- R8: On `rsm_req` in management mode all ten words are read back. The core is reloaded with the saved CR0, EFLAGS and CS fields, `in_smm` falls, and the base becomes the value read from the base slot.
- R9: If the base slot holds a value with any of bits 14:0 set, `shutdown` rises and stays high until reset. There is then no load pulse, and later requests are not accepted.
- R10: If the I/O restart byte reads FFh at resume, EIP is loaded from the previous-EIP word and `ld_halt` is 0. Otherwise EIP is loaded from the EIP word.
- R11: `ld_halt` is 1 at resume only when the core was halted at acceptance, the halt slot reads nonzero, and R10 does not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req | input | 1 | Management interrupt request pulse |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| store_pending | input | 1 | Core store queue not empty |
| rsm_req | input | 1 | Handler requests resume |
| core_halted | input | 1 | Core is in the halted state |
| core_io_insn | input | 1 | Current instruction is an I/O access |
| core_io_addr | input | 16 | Port address of that I/O access |
| core_io_dir | input | 1 | Direction of that I/O access |
| core_cr0 | input | 32 | Core CR0 |
| core_eflags | input | 32 | Core EFLAGS |
| core_eip | input | 32 | Next instruction pointer |
| core_prev_eip | input | 32 | Pointer of the current instruction |
| core_cs_sel | input | 16 | Code segment selector |
| core_cs_base | input | 32 | Code segment base |
| ld_valid | output | 1 | One-cycle strobe to load the core registers |
| ld_cr0 | output | 32 | CR0 to load |
| ld_eflags | output | 32 | EFLAGS to load |
| ld_eip | output | 32 | EIP to load |
| ld_cs_sel | output | 16 | CS selector to load |
| ld_cs_base | output | 32 | CS base to load |
| ld_halt | output | 1 | Core re-enters the halted state |
| in_smm | output | 1 | Management mode active, interrupts and NMI masked |
| busy | output | 1 | Acceptance through last save write |
| shutdown | output | 1 | Sticky shutdown after a bad base |
| mem_we | output | 1 | Save memory write strobe |
| mem_re | output | 1 | Save memory read strobe |
| mem_addr | output | 32 | Save memory byte address |
| mem_wdata | output | 32 | Save memory write data |
| mem_rdata | input | 32 | Save memory read data, one cycle after `mem_re` |

## Verification
The hardest situations to reach from the ports are the ones decided by what the handler leaves in the save area: a relocated base, a misaligned base, a requested I/O re-run, and a cleared halt slot. The bench stands in for the handler. Between the entry strobe and the resume request it edits its own model of the save memory. One stimulus table covers the combinations of halted core, I/O re-run and relocation, and the next entry after a relocation is checked at the new base. The back-to-back case is reached by raising a second request while in management mode with the I/O flag dropped. After resume that request must be taken without a new pulse, and its trap word must show the valid bit cleared.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int XLEN   = 32;
  localparam int NWORDS = 10;
  localparam int CW     = $clog2(NWORDS);

  localparam int IX_CR0  = 0;
  localparam int IX_EFL  = 1;
  localparam int IX_EIP  = 2;
  localparam int IX_PEIP = 3;
  localparam int IX_CSS  = 4;
  localparam int IX_CSB  = 5;
  localparam int IX_REV  = 6;
  localparam int IX_BASE = 7;
  localparam int IX_RST  = 8;
  localparam int IX_TRAP = 9;

  localparam logic [XLEN-1:0] REV_WORD    = 32'h0003_0000;
  localparam logic [XLEN-1:0] ENTRY_EIP   = 32'h0000_8000;
  localparam logic [XLEN-1:0] ENTRY_EFL   = 32'h0000_0002;
  localparam logic [XLEN-1:0] CR0_CLR     = 32'h8000_000D;
  localparam logic [7:0]      IO_AGAIN    = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_SAVE, S_ENTER, S_SMM,
    S_LOAD, S_LAST, S_DECIDE, S_SHUT
  } smm_state_e;

  typedef struct packed {
    logic [XLEN-1:0] cr0;
    logic [XLEN-1:0] eflags;
    logic [XLEN-1:0] eip;
    logic [XLEN-1:0] prev_eip;
    logic [15:0]     cs_sel;
    logic [XLEN-1:0] cs_base;
    logic            halted;
    logic            io_valid;
    logic [15:0]     io_addr;
    logic            io_dir;
    logic [XLEN-1:0] base;
  } smm_snap_t;
endpackage

// File: rtl/smm_fsm.sv
module smm_fsm
  import smm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pend,
  input  logic             insn_boundary,
  input  logic             store_pending,
  input  logic             rsm_req,
  input  logic             misaligned,
  output smm_state_e       st,
  output logic [CW-1:0]    cnt,
  output logic             accept
);
  logic last;
  assign last   = (cnt == CW'(NWORDS - 1));
  assign accept = (st == S_IDLE) && pend && insn_boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE:   if (accept) st <= S_DRAIN;
        S_DRAIN:  if (!store_pending) begin
                    st  <= S_SAVE;
                    cnt <= '0;
                  end
        S_SAVE:   if (last) st <= S_ENTER;
                  else cnt <= cnt + 1'b1;
        S_ENTER:  st <= S_SMM;
        S_SMM:    if (rsm_req) begin
                    st  <= S_LOAD;
                    cnt <= '0;
                  end
        S_LOAD:   if (last) st <= S_LAST;
                  else cnt <= cnt + 1'b1;
        S_LAST:   st <= S_DECIDE;
        S_DECIDE: st <= misaligned ? S_SHUT : S_IDLE;
        S_SHUT:   st <= S_SHUT;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smm_save_mux.sv
module smm_save_mux
  import smm_pkg::*;
(
  input  smm_snap_t        snap,
  input  logic [CW-1:0]    idx,
  output logic [XLEN-1:0]  word
);
  always_comb begin
    word = '0;
    case (int'(idx))
      IX_CR0:  word = snap.cr0;
      IX_EFL:  word = snap.eflags;
      IX_EIP:  word = snap.eip;
      IX_PEIP: word = snap.prev_eip;
      IX_CSS:  word = {16'h0000, snap.cs_sel};
      IX_CSB:  word = snap.cs_base;
      IX_REV:  word = REV_WORD;
      IX_BASE: word = snap.base;
      IX_RST:  word = {8'h00, 8'h00, 15'h0000, snap.halted};
      IX_TRAP: word = {snap.io_addr, 14'h0000, snap.io_valid, snap.io_dir};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/smm_restore_buf.sv
module smm_restore_buf
  import smm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap_en,
  input  logic [CW-1:0]                cap_idx,
  input  logic [XLEN-1:0]              rdata,
  output logic [NWORDS-1:0][XLEN-1:0]  words
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (cap_en && (cap_idx == CW'(g)))
        words[g] <= rdata;
    end
  end
endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter logic [31:0] AREA_TOP   = 32'h0000_FFFC,
  parameter int          ALIGN_LOG2 = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smi_req,
  input  logic         insn_boundary,
  input  logic         store_pending,
  input  logic         rsm_req,
  input  logic         core_halted,
  input  logic         core_io_insn,
  input  logic [15:0]  core_io_addr,
  input  logic         core_io_dir,
  input  logic [31:0]  core_cr0,
  input  logic [31:0]  core_eflags,
  input  logic [31:0]  core_eip,
  input  logic [31:0]  core_prev_eip,
  input  logic [15:0]  core_cs_sel,
  input  logic [31:0]  core_cs_base,
  output logic         ld_valid,
  output logic [31:0]  ld_cr0,
  output logic [31:0]  ld_eflags,
  output logic [31:0]  ld_eip,
  output logic [15:0]  ld_cs_sel,
  output logic [31:0]  ld_cs_base,
  output logic         ld_halt,
  output logic         in_smm,
  output logic         busy,
  output logic         shutdown,
  output logic         mem_we,
  output logic         mem_re,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [31:0]  mem_rdata
);
  smm_state_e                  st;
  logic [CW-1:0]               cnt;
  logic                        accept;
  logic                        pend;
  logic                        misaligned;
  logic [XLEN-1:0]             smbase;
  smm_snap_t                   snap;
  logic                        rd_en_q;
  logic [CW-1:0]               rd_idx_q;
  logic [NWORDS-1:0][XLEN-1:0] rbuf;
  logic [XLEN-1:0]             save_word;
  logic                        io_again;
  logic                        halt_back;

  smm_fsm u_fsm (
    .clk(clk), .rst(rst), .pend(pend), .insn_boundary(insn_boundary),
    .store_pending(store_pending), .rsm_req(rsm_req), .misaligned(misaligned),
    .st(st), .cnt(cnt), .accept(accept)
  );

  smm_save_mux u_mux (.snap(snap), .idx(cnt), .word(save_word));

  smm_restore_buf u_buf (
    .clk(clk), .rst(rst), .cap_en(rd_en_q), .cap_idx(rd_idx_q),
    .rdata(mem_rdata), .words(rbuf)
  );

  // Pending request latch
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend && !accept) || smi_req;
  end

  // Snapshot of the core at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (accept) begin
      snap.cr0      <= core_cr0;
      snap.eflags   <= core_eflags;
      snap.eip      <= core_eip;
      snap.prev_eip <= core_prev_eip;
      snap.cs_sel   <= core_cs_sel;
      snap.cs_base  <= core_cs_base;
      snap.halted   <= core_halted;
      snap.io_valid <= core_io_insn;
      snap.io_addr  <= core_io_addr;
      snap.io_dir   <= core_io_dir;
      snap.base     <= smbase;
    end
  end

  // Read-back capture tracking (data arrives one cycle after the strobe)
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q  <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      rd_en_q  <= (st == S_LOAD);
      rd_idx_q <= cnt;
    end
  end

  assign misaligned = |rbuf[IX_BASE][ALIGN_LOG2-1:0];
  assign io_again   = (rbuf[IX_RST][23:16] == IO_AGAIN);
  assign halt_back  = !io_again && snap.halted && (rbuf[IX_RST][15:0] != 16'h0000);

  // Memory port and busy, decoded from registered state
  assign mem_we    = (st == S_SAVE);
  assign mem_re    = (st == S_LOAD);
  assign mem_addr  = smbase + AREA_TOP - (32'(cnt) << 2);
  assign mem_wdata = save_word;
  assign busy      = (st == S_DRAIN) || (st == S_SAVE);

  // Base register and core load port
  always_ff @(posedge clk) begin
    if (rst) begin
      smbase     <= RESET_BASE;
      ld_valid   <= 1'b0;
      ld_cr0     <= '0;
      ld_eflags  <= '0;
      ld_eip     <= '0;
      ld_cs_sel  <= '0;
      ld_cs_base <= '0;
      ld_halt    <= 1'b0;
      in_smm     <= 1'b0;
      shutdown   <= 1'b0;
    end else begin
      ld_valid <= 1'b0;
      if (st == S_ENTER) begin
        ld_valid   <= 1'b1;
        ld_cr0     <= snap.cr0 & ~CR0_CLR;
        ld_eflags  <= ENTRY_EFL;
        ld_eip     <= ENTRY_EIP;
        ld_cs_sel  <= smbase[19:4];
        ld_cs_base <= smbase;
        ld_halt    <= 1'b0;
        in_smm     <= 1'b1;
      end else if (st == S_DECIDE) begin
        if (misaligned) begin
          shutdown <= 1'b1;
        end else begin
          smbase     <= rbuf[IX_BASE];
          ld_valid   <= 1'b1;
          ld_cr0     <= rbuf[IX_CR0];
          ld_eflags  <= rbuf[IX_EFL];
          ld_eip     <= io_again ? rbuf[IX_PEIP] : rbuf[IX_EIP];
          ld_cs_sel  <= rbuf[IX_CSS][15:0];
          ld_cs_base <= rbuf[IX_CSB];
          ld_halt    <= halt_back;
          in_smm     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/smm_seq_chk.sv
module smm_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        insn_boundary,
  input logic        store_pending,
  input logic        busy,
  input logic        mem_we,
  input logic        mem_re,
  input logic [31:0] mem_addr,
  input logic        ld_valid,
  input logic [31:0] ld_cr0,
  input logic [31:0] ld_eip,
  input logic [31:0] ld_eflags,
  input logic        in_smm,
  input logic        shutdown
);
  // R1: acceptance only at an instruction boundary
  a_r1_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(insn_boundary));

  // R2: first save write only after the store queue was seen empty
  a_r2_drained: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(!store_pending));

  // R3: consecutive save writes step down by one word
  a_r3_descending: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 32'd4));

  // R3: writes and reads never share a cycle
  a_r3_port_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));

  // R4: entry load clears the protected CR0 bits
  a_r4_entry_cr0: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && in_smm) |-> (ld_cr0[0] == 1'b0 && ld_cr0[2] == 1'b0 &&
                              ld_cr0[3] == 1'b0 && ld_cr0[31] == 1'b0));

  // R4: entry load vector
  a_r4_entry_vec: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && in_smm) |-> (ld_eip == 32'h0000_8000 && ld_eflags == 32'h0000_0002));

  // R9: shutdown is sticky and silent
  a_r9_shut_sticky: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (shutdown && !ld_valid && !busy));
endmodule

bind smm_seq smm_seq_chk u_chk (
  .clk(clk), .rst(rst), .insn_boundary(insn_boundary),
  .store_pending(store_pending), .busy(busy), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .ld_valid(ld_valid),
  .ld_cr0(ld_cr0), .ld_eip(ld_eip), .ld_eflags(ld_eflags),
  .in_smm(in_smm), .shutdown(shutdown)
);

// File: tb/smm_seq_bench.sv
module smm_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, smi_req, insn_boundary, store_pending, rsm_req;
  logic core_halted, core_io_insn, core_io_dir;
  logic [15:0] core_io_addr, core_cs_sel;
  logic [31:0] core_cr0, core_eflags, core_eip, core_prev_eip, core_cs_base;
  logic ld_valid, ld_halt, in_smm, busy, shutdown, mem_we, mem_re;
  logic [31:0] ld_cr0, ld_eflags, ld_eip, ld_cs_base, mem_addr, mem_wdata;
  logic [15:0] ld_cs_sel;
  logic [31:0] mem_rdata;

  smm_seq u_smm_seq (.*);

  logic [31:0] smram [logic [31:0]];
  int wr_cnt = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      smram[mem_addr] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_re) mem_rdata <= smram.exists(mem_addr) ? smram[mem_addr] : 32'h0;
  end

  function automatic logic [31:0] waddr(input logic [31:0] base, input int k);
    return base + 32'h0000_FFFC - 32'(4 * k);
  endfunction

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return smram.exists(a) ? smram[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ld(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ld_valid) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_smi();
    @(negedge clk) smi_req = 1'b1;
    @(negedge clk) smi_req = 1'b0;
  endtask

  task automatic pulse_rsm();
    @(negedge clk) rsm_req = 1'b1;
    @(negedge clk) rsm_req = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] cr0;
    logic [31:0] efl;
    logic [31:0] eip;
    logic [31:0] peip;
    logic        halted;
    logic        io;
    logic [15:0] ioaddr;
    logic        iodir;
    logic [31:0] hbase;
    logic        hff;
    logic        hclr;
    logic [31:0] ebase;
    logic [31:0] reip;
    logic        rhalt;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'hFFFF_FFFF, 32'h0000_0246, 32'h0000_1000, 32'h0000_0FFE, 1'b0, 1'b0, 16'h0000, 1'b0,
      32'h0003_0000, 1'b0, 1'b0, 32'h0003_0000, 32'h0000_1000, 1'b0},
    '{32'h8000_0011, 32'h0000_0202, 32'h0000_2004, 32'h0000_2003, 1'b1, 1'b0, 16'h0000, 1'b0,
      32'h0003_0000, 1'b0, 1'b0, 32'h0003_0000, 32'h0000_2004, 1'b1},
    '{32'h0000_000D, 32'h0000_3202, 32'h0000_2104, 32'h0000_2103, 1'b1, 1'b0, 16'h0000, 1'b0,
      32'h0003_0000, 1'b0, 1'b1, 32'h0003_0000, 32'h0000_2104, 1'b0},
    '{32'h0000_0001, 32'h0000_0046, 32'h0000_3002, 32'h0000_3000, 1'b0, 1'b1, 16'h0CF8, 1'b1,
      32'h0004_8000, 1'b1, 1'b0, 32'h0003_0000, 32'h0000_3000, 1'b0},
    '{32'h1234_5678, 32'h0000_0086, 32'h0000_4010, 32'h0000_400C, 1'b1, 1'b1, 16'h0080, 1'b0,
      32'h0003_0000, 1'b1, 1'b0, 32'h0004_8000, 32'h0000_400C, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int w0;
    logic [31:0] a;
    rst = 1'b1; smi_req = 1'b0; insn_boundary = 1'b1; store_pending = 1'b0; rsm_req = 1'b0;
    core_halted = 1'b0; core_io_insn = 1'b0; core_io_dir = 1'b0; core_io_addr = 16'h0;
    core_cs_sel = 16'h0008; core_cs_base = 32'h0001_0000;
    core_cr0 = '0; core_eflags = '0; core_eip = '0; core_prev_eip = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state
    check("R5 busy", 32'(busy), 32'd0);
    check("R5 in_smm", 32'(in_smm), 32'd0);
    check("R5 ld_valid", 32'(ld_valid), 32'd0);
    check("R5 shutdown", 32'(shutdown), 32'd0);
    check("R5 mem_we", 32'(mem_we), 32'd0);

    for (int v = 0; v < 5; v++) begin
      vec_t t;
      t = VECS[v];
      core_cr0 = t.cr0; core_eflags = t.efl; core_eip = t.eip; core_prev_eip = t.peip;
      core_halted = t.halted; core_io_insn = t.io; core_io_addr = t.ioaddr; core_io_dir = t.iodir;
      pulse_smi();
      wait_ld(seen);
      check("R4 entry strobe", 32'(seen), 32'd1);
      check("R4 entry eip", ld_eip, 32'h0000_8000);
      check("R4 entry eflags", ld_eflags, 32'h0000_0002);
      check("R4 entry cr0", ld_cr0, t.cr0 & 32'h7FFF_FFF2);
      check("R4 R5 entry cs base", ld_cs_base, t.ebase);
      check("R4 entry cs sel", 32'(ld_cs_sel), 32'(t.ebase[19:4]));
      check("R4 in_smm", 32'(in_smm), 32'd1);
      check("R3 saved cr0", rdw(waddr(t.ebase, 0)), t.cr0);
      check("R3 saved eip", rdw(waddr(t.ebase, 2)), t.eip);
      check("R3 saved prev eip", rdw(waddr(t.ebase, 3)), t.peip);
      check("R3 saved base", rdw(waddr(t.ebase, 7)), t.ebase);
      check("R7 revision", rdw(waddr(t.ebase, 6)), 32'h0003_0000);
      check("R7 restart word", rdw(waddr(t.ebase, 8)), 32'(t.halted));
      check("R6 trap word", rdw(waddr(t.ebase, 9)), {t.ioaddr, 14'h0, t.io, t.iodir});
      // handler edits
      smram[waddr(t.ebase, 7)] = t.hbase;
      a = waddr(t.ebase, 8);
      if (t.hff)  smram[a] = smram[a] | 32'h00FF_0000;
      if (t.hclr) smram[a] = smram[a] & 32'hFFFF_0000;
      pulse_rsm();
      wait_ld(seen);
      check("R8 resume strobe", 32'(seen), 32'd1);
      check("R10 resume eip", ld_eip, t.reip);
      check("R11 resume halt", 32'(ld_halt), 32'(t.rhalt));
      check("R8 resume eflags", ld_eflags, t.efl);
      check("R8 resume cr0", ld_cr0, t.cr0);
      check("R8 resume cs", {ld_cs_sel, ld_cs_base[15:0]}, {16'h0008, 16'h0000});
      check("R8 in_smm low", 32'(in_smm), 32'd0);
    end
    core_io_insn = 1'b0; core_halted = 1'b0;

    // R1: no acceptance without a boundary
    insn_boundary = 1'b0;
    pulse_smi();
    repeat (10) @(negedge clk);
    check("R1 held off busy", 32'(busy), 32'd0);
    check("R1 held off in_smm", 32'(in_smm), 32'd0);
    insn_boundary = 1'b1;
    wait_ld(seen);
    check("R1 taken at boundary", 32'({seen, in_smm}), 32'd3);
    pulse_rsm();
    wait_ld(seen);

    // R2: drain before saving, busy until last write
    store_pending = 1'b1;
    w0 = wr_cnt;
    pulse_smi();
    repeat (8) @(negedge clk);
    check("R2 busy while draining", 32'(busy), 32'd1);
    check("R2 no write while draining", 32'(wr_cnt - w0), 32'd0);
    store_pending = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    check("R2 R3 writes when busy falls", 32'(wr_cnt - w0), 32'd10);
    wait_ld(seen);
    check("R2 entry after save", 32'(seen), 32'd1);
    pulse_rsm();
    wait_ld(seen);

    // R6/R1: back-to-back pair, second one not on an I/O instruction
    core_io_insn = 1'b1; core_io_addr = 16'h0060; core_io_dir = 1'b1;
    pulse_smi();
    wait_ld(seen);
    check("R6 first trap word", rdw(waddr(32'h0003_0000, 9)), 32'h0060_0003);
    core_io_insn = 1'b0;
    pulse_smi();
    repeat (5) @(negedge clk);
    check("R1 request in smm held", 32'({busy, in_smm}), 32'd1);
    pulse_rsm();
    wait_ld(seen);
    check("R1 resume before second", 32'(in_smm), 32'd0);
    wait_ld(seen);
    check("R1 second taken", 32'({seen, in_smm}), 32'd3);
    check("R6 second trap word", rdw(waddr(32'h0003_0000, 9)), 32'h0060_0001);
    pulse_rsm();
    wait_ld(seen);

    // R9: misaligned base leads to shutdown
    pulse_smi();
    wait_ld(seen);
    smram[waddr(32'h0003_0000, 7)] = 32'h0003_4000;
    pulse_rsm();
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ld_valid) seen = 1'b1;
    end
    check("R9 shutdown", 32'(shutdown), 32'd1);
    check("R9 no load", 32'(seen), 32'd0);
    pulse_smi();
    repeat (10) @(negedge clk);
    check("R9 no accept", 32'({busy, mem_we}), 32'd0);
    check("R9 sticky", 32'(shutdown), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule